// File: doc/BRIEF.md
# Three-Phase Charge Transfer Clock Sequencer

This block drives the three electrode phases of a charge-coupled shift register. An electrode held high forms a potential well beneath it, so a charge packet stays under whichever electrodes are high. The sequencer steps through six sub-states in which the high phases overlap. In every sub-state one or two electrodes are high, and only one electrode changes level at each boundary. Each pass from the sixth sub-state back to the first moves the charge by exactly one pixel.

A controller loads a pixel-shift count and a dwell length and pulses `start`. The sequencer then runs the requested number of whole pixel shifts and pulses `step` at each pixel boundary. When the last shift completes, it drops `busy`, raises `done` and rests in the idle pattern. While a run is in progress, lowering `enable` freezes the waveform in place.

Top module: `ccd_phase_seq`

## Requirements
- R1: During and after reset, `phase` is 3'b011 (bit 0 = phase 1, bit 1 = phase 2, bit 2 = phase 3), and `step`, `busy` and `done` are all low. Whenever `busy` is low, `phase` is 3'b011.
- R2: Within a run, the sub-states follow the fixed order 3'b011, 3'b010, 3'b110, 3'b100, 3'b101, 3'b001. After 3'b001 the order returns to 3'b011.
- R3: From one cycle to the next, at most one bit of `phase` changes. The number of high phases is always one or two.
- R4: Each sub-state lasts `dwell` clock cycles. A `dwell` of 0 is treated as 1. The value is sampled when a run is accepted, and later changes have no effect until the next run.
- R5: A `start` pulse while idle with a nonzero `shift_count` is accepted. The first sub-state then holds for one dwell period starting with the cycle after acceptance. A `start` with `shift_count` of 0 is ignored, and so is a `start` while `busy` is high.
- R6: `step` is high for exactly one cycle at each return from 3'b001 to 3'b011. It coincides with the first cycle of the 3'b011 pattern. It is never high at any other time.
- R7: After `shift_count` returns, `busy` falls and `done` rises in the same cycle as the last `step`. `done` then holds until the next accepted run or reset, with `phase` resting at 3'b011.
- R8: While `busy` is high and `enable` is low, `phase` and the dwell progress hold, and `step` stays low. Resuming continues with the remaining cycles of the dwell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run enable; low freezes an active run |
| start | input | 1 | Launch request, sampled while idle |
| shift_count | input | CNT_W | Number of whole pixel shifts to perform |
| dwell | input | DWELL_W | Clock cycles per sub-state (0 acts as 1) |
| phase | output | 3 | Electrode phase levels, bit 0 = phase 1 |
| step | output | 1 | One-cycle pulse per completed pixel shift |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed; held until the next launch |

## Verification
The hardest situation to reach is a pause that begins exactly on a pixel boundary, in the cycle `step` is high. There the pulse must not repeat while the waveform is frozen. The bench reaches it by building its expected timeline from the dwell and count, then dropping `enable` on the edge right after the computed wrap cycle. The stimulus also injects a second `start`, with a different count and dwell, into the middle of a run, and issues a zero-count launch right after a completed run. These show that neither the waveform nor the held `done` is disturbed.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

   // Six overlapping sub-states, in transfer order.
   typedef enum logic [2:0] {
      SS_P12 = 3'd0,
      SS_P2  = 3'd1,
      SS_P23 = 3'd2,
      SS_P3  = 3'd3,
      SS_P31 = 3'd4,
      SS_P1  = 3'd5
   } sub_e;

   localparam int unsigned NUM_PHASES = 3;

   // Electrode levels for a sub-state; bit 0 is phase 1.
   function automatic logic [NUM_PHASES-1:0] drive_of(sub_e s);
      case (s)
         SS_P12:  return 3'b011;
         SS_P2:   return 3'b010;
         SS_P23:  return 3'b110;
         SS_P3:   return 3'b100;
         SS_P31:  return 3'b101;
         SS_P1:   return 3'b001;
         default: return 3'b011;
      endcase
   endfunction

   function automatic sub_e next_sub(sub_e s);
      if (s == SS_P1) return SS_P12;
      return sub_e'(s + 3'd1);
   endfunction

endpackage

// File: rtl/ccd_dwell_timer.sv
module ccd_dwell_timer #(
   parameter int DWELL_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic [DWELL_W-1:0] dwell_in,
   input  logic               tick_en,
   output logic               expire
);
   logic [DWELL_W-1:0] len_q;
   logic [DWELL_W-1:0] cnt_q;

   assign expire = tick_en && (cnt_q == len_q - DWELL_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         len_q <= DWELL_W'(1);
         cnt_q <= '0;
      end else if (load) begin
         len_q <= (dwell_in == '0) ? DWELL_W'(1) : dwell_in;
         cnt_q <= '0;
      end else if (tick_en) begin
         cnt_q <= expire ? '0 : cnt_q + DWELL_W'(1);
      end
   end
endmodule

// File: rtl/ccd_phase_ring.sv
module ccd_phase_ring
   import ccd_seq_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  advance,
   output logic                  wrap,
   output logic [NUM_PHASES-1:0] phase
);
   sub_e cur_q;
   sub_e nxt;

   assign nxt  = advance ? next_sub(cur_q) : cur_q;
   assign wrap = advance && (cur_q == SS_P1);

   always_ff @(posedge clk) begin
      if (rst) cur_q <= SS_P12;
      else     cur_q <= nxt;
   end

   generate
      if (REG_OUT) begin : g_reg_out
         logic [NUM_PHASES-1:0] ph_q;
         always_ff @(posedge clk) begin
            if (rst) ph_q <= drive_of(SS_P12);
            else     ph_q <= drive_of(nxt);
         end
         assign phase = ph_q;
      end else begin : g_comb_out
         assign phase = drive_of(cur_q);
      end
   endgenerate
endmodule

// File: rtl/ccd_shift_count.sv
module ccd_shift_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   input  logic [CNT_W-1:0] count_in,
   input  logic             wrap,
   output logic             busy,
   output logic             done,
   output logic             step
);
   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         left_q <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
         step   <= 1'b0;
      end else begin
         step <= 1'b0;
         if (accept) begin
            left_q <= count_in;
            busy   <= 1'b1;
            done   <= 1'b0;
         end else if (wrap) begin
            step   <= 1'b1;
            left_q <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ccd_phase_seq.sv
module ccd_phase_seq
   import ccd_seq_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int DWELL_W = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               enable,
   input  logic               start,
   input  logic [CNT_W-1:0]   shift_count,
   input  logic [DWELL_W-1:0] dwell,
   output logic [2:0]         phase,
   output logic               step,
   output logic               busy,
   output logic               done
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 1..32");
      end
      if (DWELL_W < 1 || DWELL_W > 32) begin : g_bad_dwell
         $error("DWELL_W must lie in 1..32");
      end
   endgenerate

   logic accept;
   logic tick_en;
   logic expire;
   logic wrap;

   assign accept  = start && !busy && (shift_count != '0);
   assign tick_en = busy && enable;

   ccd_dwell_timer #(.DWELL_W(DWELL_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (accept),
      .dwell_in (dwell),
      .tick_en  (tick_en),
      .expire   (expire)
   );

   ccd_phase_ring #(.REG_OUT(REG_OUT)) u_ring (
      .clk     (clk),
      .rst     (rst),
      .advance (expire),
      .wrap    (wrap),
      .phase   (phase)
   );

   ccd_shift_count #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst      (rst),
      .accept   (accept),
      .count_in (shift_count),
      .wrap     (wrap),
      .busy     (busy),
      .done     (done),
      .step     (step)
   );
endmodule

// File: rtl/ccd_phase_seq_chk.sv
module ccd_phase_seq_chk (
   input logic       clk,
   input logic       rst,
   input logic       enable,
   input logic [2:0] phase,
   input logic       step,
   input logic       busy,
   input logic       done
);
   assert_idle_rest_R1: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (phase == 3'b011));

   assert_single_edge_R3: assert property (@(posedge clk) disable iff (rst)
      $countones(phase ^ $past(phase)) <= 1);

   assert_overlap_count_R3: assert property (@(posedge clk) disable iff (rst)
      ($countones(phase) == 1) || ($countones(phase) == 2));

   assert_step_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      step |=> !step);

   assert_step_at_rest_R6: assert property (@(posedge clk) disable iff (rst)
      step |-> (phase == 3'b011));

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);

   assert_pause_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (busy && !enable) |=> ($stable(phase) && !step));
endmodule

bind ccd_phase_seq ccd_phase_seq_chk u_chk (
   .clk    (clk),
   .rst    (rst),
   .enable (enable),
   .phase  (phase),
   .step   (step),
   .busy   (busy),
   .done   (done)
);

// File: tb/ccd_phase_seq_test.sv
module ccd_phase_seq_test;
   localparam int CNT_W   = 16;
   localparam int DWELL_W = 8;
   localparam int MAX_CYC = 20000;

   typedef struct packed {
      logic [2:0] ph;
      logic       stb;
      logic       bsy;
      logic       dn;
   } obs_t;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               enable = 1'b1;
   logic               start = 1'b0;
   logic [CNT_W-1:0]   shift_count = '0;
   logic [DWELL_W-1:0] dwell = '0;
   logic [2:0]         phase;
   logic               step;
   logic               busy;
   logic               done;

   int   n_vec = 0;
   int   n_bad = 0;
   bit   finished = 1'b0;
   obs_t exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;

   ccd_phase_seq #(.CNT_W(CNT_W), .DWELL_W(DWELL_W)) uut (
      .clk(clk), .rst(rst), .enable(enable), .start(start),
      .shift_count(shift_count), .dwell(dwell),
      .phase(phase), .step(step), .busy(busy), .done(done)
   );

   // R2: sub-state order as electrode levels
   function automatic logic [2:0] pat(int s);
      case (s)
         0: return 3'b011;
         1: return 3'b010;
         2: return 3'b110;
         3: return 3'b100;
         4: return 3'b101;
         default: return 3'b001;
      endcase
   endfunction

   function automatic void push(logic [2:0] ph, logic stb, logic bsy, logic dn, string t);
      obs_t o;
      o.ph = ph; o.stb = stb; o.bsy = bsy; o.dn = dn;
      exp_q.push_back(o);
      tag_q.push_back(t);
   endfunction

   // Monitor: pops one expectation per cycle, sampled after the edge.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (!rst && exp_q.size() > 0) begin
            obs_t e;
            obs_t a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a.ph = phase; a.stb = step; a.bsy = busy; a.dn = done;
            n_vec++;
            if (a !== e) begin
               n_bad++;
               $display("FAIL %s: phase/step/busy/done actual %b/%b/%b/%b expected %b/%b/%b/%b at %0t",
                        t, a.ph, a.stb, a.bsy, a.dn, e.ph, e.stb, e.bsy, e.dn, $time);
            end
         end
      end
   end

   // Driver: builds the expected timeline, then applies the stimulus.
   // Called at a negedge; returns at the negedge after the last entry.
   task automatic run_job(int n, int dw, int pause_at, int pause_len, int poke_at);
      int d;
      int total;
      d = (dw == 0) ? 1 : dw;
      total = 0;
      for (int k = 0; k < 6*d*n; k++) begin
         push(pat((k/d) % 6), (k > 0) && (k % (6*d) == 0), 1'b1, 1'b0,
              (k % (6*d) == 0) ? "R6 R5 wrap/launch" : "R2 R4 sequence");
         total++;
         if (k == pause_at) begin
            for (int p = 0; p < pause_len; p++) begin
               push(pat((k/d) % 6), 1'b0, 1'b1, 1'b0, "R8 pause hold");
               total++;
            end
         end
      end
      push(3'b011, 1'b1, 1'b0, 1'b1, "R7 final step with done");
      total++;
      for (int t = 0; t < 3; t++) begin
         push(3'b011, 1'b0, 1'b0, 1'b1, "R7 R1 rest after done");
         total++;
      end
      start = 1'b1;
      shift_count = CNT_W'(n);
      dwell = DWELL_W'(dw);
      for (int i = 1; i < total; i++) begin
         @(negedge clk);
         if (i == 1) start = 1'b0;
         if (pause_at >= 0 && i == pause_at + 1) enable = 1'b0;
         if (pause_at >= 0 && i == pause_at + pause_len + 1) enable = 1'b1;
         if (poke_at > 0 && i == poke_at) begin
            start = 1'b1;               // R5: ignored while busy
            shift_count = CNT_W'(n + 3);
            dwell = DWELL_W'(dw + 2);   // R4: sampled only at launch
         end
         if (poke_at > 0 && i == poke_at + 1) start = 1'b0;
      end
      @(negedge clk);
   endtask

   // R5: zero-count launch is ignored; done keeps its value
   task automatic zero_probe(int len, logic dn);
      for (int i = 0; i < len; i++) push(3'b011, 1'b0, 1'b0, dn, "R5 zero count ignored");
      start = 1'b1;
      shift_count = '0;
      dwell = DWELL_W'(2);
      for (int i = 1; i < len; i++) begin
         @(negedge clk);
         if (i == 1) start = 1'b0;
      end
      @(negedge clk);
   endtask

   initial begin
      #(MAX_CYC * 20);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      n_vec++;
      if ({phase, step, busy, done} !== {3'b011, 3'b000}) begin
         n_bad++;
         $display("FAIL R1 reset: actual %b expected %b", {phase, step, busy, done}, 6'b011000);
      end
      rst = 1'b0;
      @(negedge clk);
      zero_probe(3, 1'b0);                 // R5, R1 before any run
      run_job(1, 1, -1, 0, 0);             // R2 R6 R7 shortest run
      run_job(3, 2, 7, 4, 0);              // R4 R8 pause mid sub-state
      run_job(2, 0, -1, 0, 3);             // R4 dwell 0 acts as 1; R5 busy start ignored
      zero_probe(4, 1'b1);                 // R5 R7 done held across ignored launch
      run_job(2, 3, 18, 3, 0);             // R8 R6 pause on a wrap cycle
      run_job(1, 4, -1, 0, 10);            // R4 dwell change mid-run ignored
      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule